// File: doc/BRIEF.md
# Free-Run Timer with Thinned Compare Interrupt

This block is a 16-bit up-counting timer that never stops. A compare register sets the length of its cycle: when the count matches the compare value, the counter goes back to zero on its next advance. The block has two interrupt sources. The first is the compare-clear event. The second is zero detection, meaning the counter has just been loaded with zero. Each source has a sticky status flag and an enable bit. A single interrupt line combines the two enabled sources.

The compare-clear flag can be thinned. A 3-bit select value k means the flag is raised only on every (k+1)th match. Software can therefore take one interrupt per several timer periods without counting them itself. The counter is driven either by the system clock or by an external clock pin. The external pin is synchronized and edge-detected, so the counter moves once per rising edge of that pin.

All state is reached through a small register bus with byte enables. The bus has three locations: control/status, compare value, and live counter value.

Top module: `frtimer_top`

## Requirements
- R1: After reset the control word reads 0x0000, the compare register reads 0xFFFF, and `irq` is 0.
- R2: With the internal clock selected (control bit 15 = 0), the counter adds 1 every cycle. On the cycle after it equals the compare value it reads 0, so one period is compare+1 cycles.
- R3: With the external clock selected (bit 15 = 1), the counter adds exactly 1 per rising edge of `ext_clk_in`, a few cycles after that edge. While the pin is steady, the counter holds.
- R4: Bits 12:10 hold a select value k. After any write to the control high byte, the compare-clear flag (bit 9) is first set at the (k+1)th compare-clear event. This holds for every k from 0 to 7.
- R5: The zero-detect flag (bit 14) is set on the cycle in which the counter is loaded with 0 by a compare-clear event or a rollover.
- R6: A control write with a 0 in bit 14 or bit 9 clears that flag. A 1 in the same bit leaves the flag unchanged.
- R7: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when (bit 14 AND bit 13) or (bit 9 AND bit 8) is true.
- R9: The control fields sit in the high byte: bit 15 clock select, 14 zero flag, 13 zero enable, 12:10 select, 9 compare flag, 8 compare enable. The low byte reads 0. Writes without byte enable 1 leave the control word unchanged.
- R10: The compare register (address 1) takes each byte of a write only when that byte's enable is set. The counter is read at address 2 and address 3 reads 0. The control word sits at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables for the write |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| ext_clk_in | input | 1 | External counting clock, asynchronous |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a software clear landing in exactly the cycle in which hardware sets the same flag. It needs a known counter phase relative to a bus write.

The stimulus freezes the counter by selecting the external clock with the pin held low. It then reads the frozen count and restarts the counter with a single control write. From that point the cycle of every later compare-clear event follows arithmetically. This lets the bench time a clearing write onto the set cycle. The same frozen-start method lets the bench sweep all eight select values over several compare values and predict exactly which cycle raises each flag.

// File: rtl/frtimer_pkg.sv
// Shared constants and the control-byte layout for the free-run timer.
// Assumes a 16-bit register bus with one byte enable per byte lane.
package frtimer_pkg;

    localparam int BUS_W   = 16;
    localparam int LANES   = BUS_W / 8;
    localparam int ADDR_W  = 2;
    localparam int MSEL_W  = 3;
    localparam int CTRL_LANE = 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;

    // Packed in bit order 15 down to 8 of the control word.
    typedef struct packed {
        logic              clk_ext;
        logic              zflag;
        logic              zen;
        logic [MSEL_W-1:0] msel;
        logic              cflag;
        logic              cen;
    } ctrl_t;

endpackage

// File: rtl/frtimer_extsync.sv
// Brings the asynchronous external clock pin into the system clock domain
// and turns each rising edge into a one-cycle pulse.
// Assumes the pin stays high and low for longer than one system clock each.
module frtimer_extsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic ext_rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_in;
            end
        end else begin : g_chain
            // Shift the pin through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], ext_in};
            end
        end
    endgenerate

    // Delay the synchronized level by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign ext_rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/frtimer_count.sv
// Up-counter with compare clear. On each tick it advances by one. If it
// equals the compare value it loads zero instead. Reports the compare-clear
// event and the zero-load event in the tick cycle.
// Assumes tick is a single-cycle qualifier in the system clock domain.
module frtimer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             cmp_evt,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    logic hit;

    assign hit      = (cnt == cmp);
    assign cmp_evt  = tick && hit;
    assign zero_evt = tick && (hit || cnt == MAXV);

    // Advance, clear on match, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (cmp_evt)  cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/frtimer_regs.sv
// Register bank: the control/status byte, the compare register, the match
// thinning counter and the read multiplexer.
// Assumes CNT_W is no wider than the bus. Writes are single-cycle strobes.
module frtimer_regs
    import frtimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [LANES-1:0]  bus_be,
    input  logic              cmp_evt,
    input  logic              zero_evt,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmp,
    output logic              cf_set,
    output logic [BUS_W-1:0]  rdata
);

    logic              wr_ctrl;
    logic              wr_cmp;
    ctrl_t             wd;
    logic [MSEL_W-1:0] mcnt;

    assign wr_ctrl = bus_wr_en && (bus_addr == A_CTRL) && bus_be[CTRL_LANE];
    assign wr_cmp  = bus_wr_en && (bus_addr == A_CMP);
    assign wd      = ctrl_t'(bus_wdata[CTRL_LANE*8 +: 8]);
    assign cf_set  = cmp_evt && (mcnt == ctrl.msel);

    // Count compare-clear events; restart on wrap or on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mcnt <= '0;
        else if (wr_ctrl)             mcnt <= '0;
        else if (cmp_evt && cf_set)   mcnt <= '0;
        else if (cmp_evt)             mcnt <= mcnt + 1'b1;
    end

    // Control fields and sticky flags; a hardware set beats a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.clk_ext <= wd.clk_ext;
            ctrl.zen     <= wd.zen;
            ctrl.msel    <= wd.msel;
            ctrl.cen     <= wd.cen;
            ctrl.zflag   <= zero_evt | (ctrl.zflag & wd.zflag);
            ctrl.cflag   <= cf_set   | (ctrl.cflag & wd.cflag);
        end else begin
            ctrl.zflag   <= ctrl.zflag | zero_evt;
            ctrl.cflag   <= ctrl.cflag | cf_set;
        end
    end

    generate
        for (genvar b = 0; b < CNT_W; b++) begin : g_cmp_bit
            // Each compare bit takes the write when its byte lane is enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)                      cmp[b] <= 1'b1;
                else if (wr_cmp && bus_be[b/8])  cmp[b] <= bus_wdata[b];
            end
        end
    endgenerate

    // Select the register addressed on the bus.
    always_comb begin
        case (bus_addr)
            A_CTRL:  rdata = {ctrl, 8'h00};
            A_CMP:   rdata = BUS_W'(cmp);
            A_CNT:   rdata = BUS_W'(cnt);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/frtimer_top.sv
// Free-run timer top. Picks the counting tick, wires the counter and the
// register bank, and forms the interrupt request from flags and enables.
// Assumes ext_clk_in is asynchronous and slower than clk.
module frtimer_top
    import frtimer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [LANES-1:0]  bus_be,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ext_clk_in,
    output logic              irq
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             ext_rise;
    logic             tick;
    logic             cmp_evt;
    logic             zero_evt;
    logic             cf_set;

    frtimer_extsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_clk_in),
        .ext_rise (ext_rise)
    );

    assign tick = ctrl_q.clk_ext ? ext_rise : 1'b1;

    frtimer_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmp      (cmp_q),
        .cnt      (cnt_q),
        .cmp_evt  (cmp_evt),
        .zero_evt (zero_evt)
    );

    frtimer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .cmp_evt   (cmp_evt),
        .zero_evt  (zero_evt),
        .cnt       (cnt_q),
        .ctrl      (ctrl_q),
        .cmp       (cmp_q),
        .cf_set    (cf_set),
        .rdata     (bus_rdata)
    );

    assign irq = (ctrl_q.zflag & ctrl_q.zen) | (ctrl_q.cflag & ctrl_q.cen);

endmodule

// File: rtl/frtimer_chk.sv
// Assertion checker for the free-run timer, attached to the top by bind.
// Observes the tick, counter, compare value, events and flags.
module frtimer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ext_sel,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             cmp_evt,
    input logic             cf_set,
    input logic             zflag,
    input logic             cflag,
    input logic             irq
);

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == cmp) |=> (cnt == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != cmp) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R3
    ext_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && tick) |=> (!tick || !ext_sel));

    // R4
    cflag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cflag) |-> $past(cmp_evt));

    // R5
    zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zflag) |-> (cnt == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_set |=> cflag);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (zflag || cflag));

endmodule

bind frtimer_top frtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ext_sel (ctrl_q.clk_ext),
    .cnt     (cnt_q),
    .cmp     (cmp_q),
    .cmp_evt (cmp_evt),
    .cf_set  (cf_set),
    .zflag   (ctrl_q.zflag),
    .cflag   (ctrl_q.cflag),
    .irq     (irq)
);

// File: tb/frtimer_top_bench.sv
module frtimer_top_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_rdata;
    logic        ext_clk_in = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    frtimer_top u_frtimer_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr_en  (bus_wr_en),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .bus_rdata  (bus_rdata),
        .ext_clk_in (ext_clk_in),
        .irq        (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic ext, input logic zf, input logic ze,
                                       input logic [2:0] ms, input logic cf, input logic ce);
        return {ext, zf, ze, ms, cf, ce, 8'h00};
    endfunction

    // Write at the next edge; returns at the negedge after it.
    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic freeze();
        wr(2'd0, mk(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0), 2'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v, c0, c1, n, nz, fc, fz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 cmp", v, 16'hFFFF);
        check("R1 irq", int'(irq), 0);

        freeze();
        // R4 and R5 sweep: every select value over several periods.
        for (int cmp = 3; cmp <= 6; cmp++) begin
            wr(2'd1, 16'(cmp), 2'b11);
            for (int k = 0; k < 8; k++) begin
                freeze();
                rd(2'd2, c0);
                wr(2'd0, mk(1'b0, 1'b0, 1'b0, 3'(k), 1'b0, 1'b0), 2'b10);
                n  = cmp - c0 + 1 + k * (cmp + 1);
                nz = cmp - c0 + 1;
                fc = -1; fz = -1;
                bus_addr = 2'd0;
                for (int j = 1; j <= n + 2; j++) begin
                    @(negedge clk);
                    #1;
                    if (fc < 0 && bus_rdata[9])  fc = j;
                    if (fz < 0 && bus_rdata[14]) fz = j;
                end
                check($sformatf("R4 cmp=%0d k=%0d", cmp, k), fc, n);
                check($sformatf("R5 cmp=%0d k=%0d", cmp, k), fz, nz);
            end
        end

        // R2: counter sequence with compare 6.
        freeze();
        rd(2'd2, c0);
        wr(2'd0, mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0), 2'b10);
        bus_addr = 2'd2;
        for (int j = 1; j <= 20; j++) begin
            int e;
            @(negedge clk);
            #1;
            e = (j <= 6 - c0) ? c0 + j : (j - (6 - c0) - 1) % 7;
            check($sformatf("R2 step %0d", j), int'(bus_rdata), e);
        end

        // R7: clearing write in the same cycle as the set.
        freeze();
        wr(2'd1, 16'd20, 2'b11);
        rd(2'd2, c0);
        wr(2'd0, mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0), 2'b10);
        n = 20 - c0 + 1;
        for (int j = 1; j <= n - 2; j++) @(negedge clk);
        wr(2'd0, mk(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0), 2'b10);
        rd(2'd0, v); check("R7 cflag kept", int'(v[9]), 1);

        // R6: writing 1 leaves both flags set (also freezes).
        wr(2'd0, mk(1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0), 2'b10);
        rd(2'd0, v); check("R6 write1 keep", v & 16'h4200, 16'h4200);

        // R8: every enable combination with both flags set.
        for (int ze = 0; ze < 2; ze++)
            for (int ce = 0; ce < 2; ce++) begin
                wr(2'd0, mk(1'b1, 1'b1, 1'(ze), 3'd0, 1'b1, 1'(ce)), 2'b10);
                check($sformatf("R8 ze=%0d ce=%0d", ze, ce), int'(irq), ze | ce);
            end

        // R6 and R8: clear zero flag only, then compare flag only.
        wr(2'd0, mk(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1), 2'b10);
        rd(2'd0, v); check("R6 clear zflag", v & 16'h4200, 16'h0200);
        check("R8 cflag only", int'(irq), 1);
        wr(2'd0, mk(1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1), 2'b10);
        rd(2'd0, v); check("R6 clear cflag", v & 16'h4200, 16'h0000);
        check("R8 no flags", int'(irq), 0);

        // R9: layout, and low-lane-only writes ignored.
        wr(2'd0, mk(1'b1, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0), 2'b10);
        rd(2'd0, v); check("R9 layout", v, 16'hB400);
        wr(2'd0, 16'hFFFF, 2'b01);
        rd(2'd0, v); check("R9 low lane ignored", v, 16'hB400);

        // R10: compare byte lanes and spare address.
        wr(2'd1, 16'hAB12, 2'b01);
        rd(2'd1, v); check("R10 low lane", v, 16'h0012);
        wr(2'd1, 16'h3456, 2'b10);
        rd(2'd1, v); check("R10 high lane", v, 16'h3412);
        rd(2'd3, v); check("R10 spare", v, 0);

        // R3: external clock edges.
        wr(2'd1, 16'hFFFF, 2'b11);
        rd(2'd2, c0);
        repeat (8) @(negedge clk);
        rd(2'd2, v); check("R3 hold", v, c0);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); ext_clk_in = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        rd(2'd2, c1); check("R3 five edges", c1, c0 + 5);
        @(negedge clk); ext_clk_in = 1'b1;
        repeat (10) @(negedge clk);
        rd(2'd2, v); check("R3 one edge then steady", v, c1 + 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule